// File: doc/BRIEF.md
# Programmable LCD Segment Bit Mapper

This block produces the segment data for an LCD panel with 50 segment lines and up to 16 common phases. A display RAM of 72 bytes holds the picture. Normally each segment reads a fixed byte and bit of that RAM. When remapping is enabled, every segment/common pair instead looks up its own table entry. The entry gives a display-RAM byte and a bit inside that byte. This lets the panel wiring be matched in software without moving picture data around.

The block runs its own slot timer. At every common-slot boundary it advances the common index, evaluates all 50 segment bits for the new common in one step and registers them. The outputs hold steady for the whole slot. A single write port loads the display RAM, the byte-address table and the bit-index table.

Remapping is permitted only for some settings. The enable and the type-3 map selection must both be set, and the duty must be short enough for the selected frame rate. In every other case the block falls back to direct mapping.

Top module: `lcd_segmap`

## Requirements
- R1: While reset is low, and until the first slot boundary, seg_o is all zero, com_o is 0 and slot_o is 0. The first slot_o pulse comes exactly SLOT_CYCLES clock cycles after reset is released, and it shows common 0.
- R2: slot_o is high for one cycle out of every SLOT_CYCLES cycles. On each pulse, com_o moves to the previous common plus one. If the previous common was already at or above duty_i, com_o goes to 0 instead. duty_i is sampled at the boundary, and the duty code is the number of commons minus one.
- R3: seg_o and com_o change only in cycles where slot_o is high.
- R4: With remapping inactive, segment s in common c reads display byte s + 50*(c/8), bit c mod 8.
- R5: With remapping active, segment s in common c reads table entry c*50 + s. The byte-address table gives the byte, an 8-bit value. The bit-index table gives the bit number, a 3-bit value.
- R6: A selected byte number of 72 or above drives the segment to 0.
- R7: Remapping is active only if all three conditions hold: remap_en_i is 1, map_type3_i is 1, and duty_i is no greater than a limit set by rate_i. The rate codes are 0 for about 64 Hz, 1 for about 73 Hz, 2 for about 85 Hz and 3 for about 102 Hz. The limits are 7 for rate codes 0 and 1, 6 for code 2 and 5 for code 3.
- R8: For duty codes 8 to 15, the direct mapping is used whatever the enable inputs say.
- R9: wr_tgt_i selects what a write changes. Code 0 writes display byte wr_addr_i, taking addresses 0 to 71 only. Code 1 writes the byte-address entry wr_addr_i and code 2 writes the bit-index entry from wr_data_i[2:0]; both take entries 0 to 399 only. Code 3 changes nothing. A write first shows at the next slot boundary after its clock edge, and never within the slot in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_tgt_i | input | 2 | Write target: 0 RAM, 1 byte-address table, 2 bit-index table, 3 none |
| wr_addr_i | input | 9 | RAM byte number or table entry number |
| wr_data_i | input | 8 | Write data |
| duty_i | input | 4 | Number of commons minus one |
| rate_i | input | 2 | Frame-rate code |
| remap_en_i | input | 1 | Remapping enable |
| map_type3_i | input | 1 | Type-3 direct map selected |
| seg_o | output | 50 | Segment bits for the current common |
| com_o | output | 4 | Current common index |
| slot_o | output | 1 | One-cycle pulse when a new slot's data appears |

## Verification
Each slot_o pulse is due exactly SLOT_CYCLES rising edges after the previous one, or after reset release for the first pulse. The new seg_o and com_o appear in the same cycle as the pulse. A write or mode change made on an edge before a boundary shows up at that boundary and not earlier. The bench therefore drives on falling edges and counts falling edges between pulses. It compares seg_o and com_o against arithmetic expectations on the falling edge where slot_o is seen high. On every other falling edge inside the slot, it confirms that nothing has moved.

// File: rtl/lcd_segmap_pkg.sv
package lcd_segmap_pkg;

   typedef enum logic [1:0] {
      WR_RAM  = 2'd0,
      WR_ADDR = 2'd1,
      WR_BIT  = 2'd2,
      WR_NONE = 2'd3
   } wr_target_e;

   typedef enum logic [1:0] {
      RATE_64  = 2'd0,
      RATE_73  = 2'd1,
      RATE_85  = 2'd2,
      RATE_102 = 2'd3
   } frame_rate_e;

   localparam int BYTE_W = 8;

   // largest duty code (commons - 1) allowed to remap at a frame rate
   function automatic int max_remap_duty(input logic [1:0] rate);
      case (rate)
         RATE_64, RATE_73: return 7;
         RATE_85:          return 6;
         default:          return 5;
      endcase
   endfunction

endpackage

// File: rtl/lcd_segmap_timing.sv
module lcd_segmap_timing #(
   parameter int SLOT_CYCLES = 32,
   parameter int COM_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [COM_W-1:0] duty_i,
   output logic             boundary_o,
   output logic [COM_W-1:0] com_q_o,
   output logic [COM_W-1:0] next_com_o
);
   localparam int CNT_W = $clog2(SLOT_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic [COM_W-1:0] com_q;
   logic             started_q;

   assign boundary_o = (int'(cnt_q) == SLOT_CYCLES - 1);
   assign com_q_o    = com_q;

   always_comb begin
      if (!started_q || int'(com_q) >= int'(duty_i)) next_com_o = '0;
      else                                          next_com_o = com_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         com_q     <= '0;
         started_q <= 1'b0;
      end else if (boundary_o) begin
         cnt_q     <= '0;
         com_q     <= next_com_o;
         started_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcd_segmap_gate.sv
module lcd_segmap_gate #(
   parameter int COM_W    = 4,
   parameter int MAP_COMS = 8
) (
   input  logic             remap_en_i,
   input  logic             map_type3_i,
   input  logic [COM_W-1:0] duty_i,
   input  logic [1:0]       rate_i,
   output logic             remap_ok_o
);
   import lcd_segmap_pkg::*;

   logic duty_fits;

   always_comb begin
      duty_fits = (int'(duty_i) <= max_remap_duty(rate_i)) &&
                  (int'(duty_i) < MAP_COMS);
      remap_ok_o = remap_en_i && map_type3_i && duty_fits;
   end
endmodule

// File: rtl/lcd_segmap_store.sv
module lcd_segmap_store #(
   parameter int NUM_SEG   = 50,
   parameter int MAP_COMS  = 8,
   parameter int RAM_BYTES = 72,
   parameter int COM_W     = 4,
   parameter int WR_AW     = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_tgt_i,
   input  logic [WR_AW-1:0]   wr_addr_i,
   input  logic [7:0]         wr_data_i,
   input  logic [COM_W-1:0]   look_com_i,
   input  logic               remap_i,
   output logic [NUM_SEG-1:0] bits_o
);
   import lcd_segmap_pkg::*;

   localparam int ADDR_W  = BYTE_W;
   localparam int BIT_W   = $clog2(BYTE_W);
   localparam int MAP_CW  = $clog2(MAP_COMS);
   localparam int ENTRIES = NUM_SEG * MAP_COMS;
   localparam int ENT_AW  = $clog2(ENTRIES);
   localparam int RAM_AW  = $clog2(RAM_BYTES);

   logic [BYTE_W-1:0] ram_q      [RAM_BYTES];
   logic [ADDR_W-1:0] addr_tab_q [ENTRIES];
   logic [BIT_W-1:0]  bit_tab_q  [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            addr_tab_q[i] <= '0;
            bit_tab_q[i]  <= '0;
         end
      end else if (wr_en_i) begin
         case (wr_tgt_i)
            WR_RAM:
               if (int'(wr_addr_i) < RAM_BYTES)
                  ram_q[wr_addr_i[RAM_AW-1:0]] <= wr_data_i;
            WR_ADDR:
               if (int'(wr_addr_i) < ENTRIES)
                  addr_tab_q[wr_addr_i[ENT_AW-1:0]] <= wr_data_i[ADDR_W-1:0];
            WR_BIT:
               if (int'(wr_addr_i) < ENTRIES)
                  bit_tab_q[wr_addr_i[ENT_AW-1:0]] <= wr_data_i[BIT_W-1:0];
            default: ;
         endcase
      end
   end

   // one lookup path per segment line
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [ENT_AW-1:0] ent;
      logic [ADDR_W-1:0] sel_byte;
      logic [BIT_W-1:0]  sel_bit;
      logic              in_range;

      always_comb begin
         ent = ENT_AW'(int'(look_com_i[MAP_CW-1:0]) * NUM_SEG + s);
         if (remap_i) begin
            sel_byte = addr_tab_q[ent];
            sel_bit  = bit_tab_q[ent];
         end else begin
            sel_byte = ADDR_W'(s + NUM_SEG * int'(look_com_i >> MAP_CW));
            sel_bit  = look_com_i[BIT_W-1:0];
         end
      end

      if (RAM_BYTES == (1 << ADDR_W)) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         assign in_range = int'(sel_byte) < RAM_BYTES;
      end

      assign bits_o[s] = in_range ? ram_q[sel_byte[RAM_AW-1:0]][sel_bit] : 1'b0;
   end
endmodule

// File: rtl/lcd_segmap.sv
module lcd_segmap #(
   parameter int NUM_SEG     = 50,
   parameter int MAP_COMS    = 8,
   parameter int MAX_COMS    = 16,
   parameter int RAM_BYTES   = 72,
   parameter int SLOT_CYCLES = 32,
   localparam int COM_W      = $clog2(MAX_COMS),
   localparam int ENT_AW     = $clog2(NUM_SEG * MAP_COMS),
   localparam int RAM_AW     = $clog2(RAM_BYTES),
   localparam int WR_AW      = (ENT_AW > RAM_AW) ? ENT_AW : RAM_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_tgt_i,
   input  logic [WR_AW-1:0]   wr_addr_i,
   input  logic [7:0]         wr_data_i,
   input  logic [COM_W-1:0]   duty_i,
   input  logic [1:0]         rate_i,
   input  logic               remap_en_i,
   input  logic               map_type3_i,
   output logic [NUM_SEG-1:0] seg_o,
   output logic [COM_W-1:0]   com_o,
   output logic               slot_o
);
   if (SLOT_CYCLES < 2) begin : g_bad_slot
      $error("SLOT_CYCLES must be at least 2");
   end
   if (MAP_COMS > 8 || MAP_COMS < 2) begin : g_bad_map
      $error("MAP_COMS must lie in 2..8, one bit per common in a byte");
   end
   if (MAX_COMS != 2 * MAP_COMS) begin : g_bad_max
      $error("MAX_COMS must be twice MAP_COMS");
   end
   if (RAM_BYTES > 256 || NUM_SEG * 2 > 256) begin : g_bad_ram
      $error("display bytes must be reachable by an 8-bit address");
   end

   logic               boundary;
   logic [COM_W-1:0]   com_q;
   logic [COM_W-1:0]   next_com;
   logic               remap_ok;
   logic [NUM_SEG-1:0] look_bits;
   logic [NUM_SEG-1:0] seg_q;
   logic               slot_q;

   lcd_segmap_timing #(
      .SLOT_CYCLES(SLOT_CYCLES),
      .COM_W      (COM_W)
   ) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .duty_i    (duty_i),
      .boundary_o(boundary),
      .com_q_o   (com_q),
      .next_com_o(next_com)
   );

   lcd_segmap_gate #(
      .COM_W   (COM_W),
      .MAP_COMS(MAP_COMS)
   ) u_gate (
      .remap_en_i (remap_en_i),
      .map_type3_i(map_type3_i),
      .duty_i     (duty_i),
      .rate_i     (rate_i),
      .remap_ok_o (remap_ok)
   );

   lcd_segmap_store #(
      .NUM_SEG  (NUM_SEG),
      .MAP_COMS (MAP_COMS),
      .RAM_BYTES(RAM_BYTES),
      .COM_W    (COM_W),
      .WR_AW    (WR_AW)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_tgt_i  (wr_tgt_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .look_com_i(next_com),
      .remap_i   (remap_ok),
      .bits_o    (look_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q  <= '0;
         slot_q <= 1'b0;
      end else begin
         slot_q <= boundary;
         if (boundary) seg_q <= look_bits;
      end
   end

   assign seg_o  = seg_q;
   assign com_o  = com_q;
   assign slot_o = slot_q;
endmodule

// File: rtl/lcd_segmap_chk.sv
module lcd_segmap_chk #(
   parameter int NUM_SEG     = 50,
   parameter int MAP_COMS    = 8,
   parameter int COM_W       = 4,
   parameter int SLOT_CYCLES = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               slot_o,
   input logic [NUM_SEG-1:0] seg_o,
   input logic [COM_W-1:0]   com_o,
   input logic [COM_W-1:0]   duty_i,
   input logic               remap_ok,
   input logic               remap_en_i,
   input logic               map_type3_i
);
   localparam int GW = $clog2(SLOT_CYCLES + 2) + 1;

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_q <= '0;
      else if (slot_o)                    gap_q <= GW'(1);
      else if (gap_q != {GW{1'b1}})       gap_q <= gap_q + 1'b1;
   end

   // R2: pulses are exactly SLOT_CYCLES apart (and after reset, R1)
   a_r2_slot_period: assert property (@(posedge clk) disable iff (!rst_n)
      slot_o |-> (int'(gap_q) == SLOT_CYCLES));

   a_r2_com_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot_o |-> (int'(com_o) <= int'($past(duty_i))));

   a_r2_com_step: assert property (@(posedge clk) disable iff (!rst_n)
      slot_o |-> ((com_o == '0) || (com_o == $past(com_o) + 1'b1)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_o |-> ($stable(seg_o) && $stable(com_o)));

   a_r7_gate_enables: assert property (@(posedge clk) disable iff (!rst_n)
      remap_ok |-> (remap_en_i && map_type3_i));

   a_r8_wide_duty_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(duty_i) >= MAP_COMS) |-> !remap_ok);
endmodule

bind lcd_segmap lcd_segmap_chk #(
   .NUM_SEG    (NUM_SEG),
   .MAP_COMS   (MAP_COMS),
   .COM_W      (COM_W),
   .SLOT_CYCLES(SLOT_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_o     (slot_o),
   .seg_o      (seg_o),
   .com_o      (com_o),
   .duty_i     (duty_i),
   .remap_ok   (remap_ok),
   .remap_en_i (remap_en_i),
   .map_type3_i(map_type3_i)
);

// File: tb/lcd_segmap_bench.sv
`timescale 1ns/1ps
module lcd_segmap_bench;
   localparam int NS   = 50;
   localparam int RB   = 72;
   localparam int NE   = 400;
   localparam int SLOT = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_tgt = 2'd0;
   logic [8:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  duty = '0;
   logic [1:0]  rate = '0;
   logic        en = 1'b0;
   logic        t3 = 1'b0;
   logic [NS-1:0] seg_o;
   logic [3:0]  com_o;
   logic        slot_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cur_com = 0;

   logic [7:0] mram  [RB];
   logic [7:0] maddr [NE];
   logic [2:0] mbit  [NE];

   always #2.5 clk = ~clk;

   lcd_segmap #(.SLOT_CYCLES(SLOT)) u_lcd_segmap (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_tgt_i(wr_tgt),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .duty_i(duty), .rate_i(rate),
      .remap_en_i(en), .map_type3_i(t3), .seg_o(seg_o), .com_o(com_o),
      .slot_o(slot_o)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] tgt, input int addr, input logic [7:0] d);
      wr_en = 1'b1; wr_tgt = tgt; wr_addr = 9'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_slot(output int gap, output bit steady);
      logic [NS-1:0] s0;
      logic [3:0]    c0;
      s0 = seg_o; c0 = com_o; gap = 0; steady = 1'b1;
      do begin
         @(negedge clk);
         gap++;
         if (!slot_o && (seg_o != s0 || com_o != c0)) steady = 1'b0;
      end while (!slot_o && gap < 4 * SLOT);
   endtask

   function automatic bit gate_exp(input int d, input int r, input bit e, input bit t);
      int lim;
      lim = (r < 2) ? 7 : ((r == 2) ? 6 : 5);
      return e && t && (d <= lim);
   endfunction

   function automatic logic [NS-1:0] exp_seg(input int com, input bit remap);
      logic [NS-1:0] v;
      int a, b, e;
      v = '0;
      for (int s = 0; s < NS; s++) begin
         if (remap) begin
            e = com * NS + s; a = int'(maddr[e]); b = int'(mbit[e]);
         end else begin
            a = s + NS * (com / 8); b = com % 8;
         end
         if (a < RB) v[s] = mram[a][b];
      end
      return v;
   endfunction

   function automatic logic [NS-1:0] oor_mask(input int com, input bit remap);
      logic [NS-1:0] m;
      m = '0;
      for (int s = 0; s < NS; s++) begin
         if (remap) m[s] = (int'(maddr[com * NS + s]) >= RB);
         else       m[s] = (s + NS * (com / 8)) >= RB;
      end
      return m;
   endfunction

   task automatic check_slot(input int gap, input bit steady, input bit remap);
      int ec;
      string lbl;
      ec = (cur_com >= int'(duty)) ? 0 : cur_com + 1;
      chk(gap == SLOT, "R2 slot period", 64'(gap), 64'(SLOT));
      chk(steady, "R3 outputs held mid-slot", 64'(steady), 64'd1);
      chk(int'(com_o) == ec, "R2 common sequence", 64'(com_o), 64'(ec));
      if (duty >= 4'd8)  lbl = "R8 wide duty uses direct map";
      else if (remap)    lbl = "R5 R7 remapped segments";
      else               lbl = "R4 R7 direct segments";
      chk(seg_o == exp_seg(ec, remap), lbl, 64'(seg_o), 64'(exp_seg(ec, remap)));
      chk((seg_o & oor_mask(ec, remap)) == '0, "R6 out-of-range byte off",
          64'(seg_o & oor_mask(ec, remap)), 64'd0);
      cur_com = int'(com_o);
   endtask

   task automatic run_cfg(input int d, input int r, input bit e, input bit t, input int nslots);
      int  gap;
      bit  steady;
      bit  remap;
      wait_slot(gap, steady);
      cur_com = int'(com_o);
      duty = 4'(d); rate = 2'(r); en = e; t3 = t;
      remap = gate_exp(d, r, e, t);
      for (int k = 0; k < nslots; k++) begin
         wait_slot(gap, steady);
         check_slot(gap, steady, remap);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int gap;
      bit steady;
      logic [NS-1:0] old_seg;

      repeat (4) @(negedge clk);
      chk(seg_o == '0 && com_o == 4'd0 && slot_o == 1'b0, "R1 state in reset",
          64'(seg_o), 64'd0);
      rst_n = 1'b1;
      chk(seg_o == '0 && com_o == 4'd0 && slot_o == 1'b0, "R1 state after release",
          64'(seg_o), 64'd0);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!slot_o && gap < 4 * SLOT);
      chk(gap == SLOT, "R1 first slot timing", 64'(gap), 64'(SLOT));
      chk(com_o == 4'd0, "R1 first slot common", 64'(com_o), 64'd0);
      chk(seg_o == '0, "R1 empty RAM drives zero", 64'(seg_o), 64'd0);

      // R9: load RAM and both tables through the write port
      for (int i = 0; i < RB; i++) begin
         mram[i] = 8'((i * 37 + 11) % 256);
         wr(2'd0, i, mram[i]);
      end
      for (int i = 0; i < NE; i++) begin
         maddr[i] = 8'((i * 7 + 3) % 80);
         wr(2'd1, i, maddr[i]);
      end
      for (int i = 0; i < NE; i++) begin
         mbit[i] = 3'((i * 5) % 8);
         wr(2'd2, i, {5'b10101, mbit[i]});
      end

      // R7 R8: every duty code under every frame rate with remapping requested
      for (int r = 0; r < 4; r++)
         for (int d = 0; d < 16; d++)
            run_cfg(d, r, 1'b1, 1'b1, d + 2);
      // R7: a missing enable or a missing type-3 selection forces direct mapping
      run_cfg(7, 0, 1'b0, 1'b1, 9);
      run_cfg(3, 1, 1'b1, 1'b0, 5);
      run_cfg(15, 3, 1'b0, 1'b0, 17);

      // R9: a RAM write lands at the next boundary, not within the slot
      run_cfg(0, 0, 1'b0, 1'b0, 1);
      old_seg = seg_o;
      mram[3] = mram[3] ^ 8'h01;
      wr(2'd0, 3, mram[3]);
      chk(seg_o == old_seg, "R9 write not visible mid-slot", 64'(seg_o), 64'(old_seg));
      wait_slot(gap, steady);
      chk(steady, "R9 R3 held until boundary", 64'(steady), 64'd1);
      chk(seg_o == exp_seg(0, 1'b0), "R9 RAM write at next boundary",
          64'(seg_o), 64'(exp_seg(0, 1'b0)));

      // R9: target code 3 changes nothing, even aimed at byte 0
      wr(2'd3, 0, ~mram[0]);
      wait_slot(gap, steady);
      chk(seg_o == exp_seg(0, 1'b0), "R9 target 3 ignored",
          64'(seg_o), 64'(exp_seg(0, 1'b0)));

      // R9 R5: rewrite one table entry while remapping
      duty = 4'd0; rate = 2'd3; en = 1'b1; t3 = 1'b1;
      maddr[5] = 8'd70; mbit[5] = 3'd6;
      wr(2'd1, 5, maddr[5]);
      wr(2'd2, 5, 8'(mbit[5]));
      wait_slot(gap, steady);
      chk(seg_o == exp_seg(0, 1'b1), "R9 R5 table write at next boundary",
          64'(seg_o), 64'(exp_seg(0, 1'b1)));

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule